// File: doc/BRIEF.md
# Command-Byte Serial Register Slave

This block is the slave end of a four-wire serial port: serial clock, serial data in, serial data out and an active-low select. A host uses it to read and write a bank of internal registers. Every transfer opens with an 8-bit command byte. The command gives the direction and a 5-bit register address. One, two or three data bytes follow, most significant byte first. The number of data bytes depends on the addressed register.

All serial inputs are brought into the system clock domain and their edges are found there. Data in is sampled on the falling serial clock edge, and data out is launched on the rising edge. A write places each completed data byte into its byte lane at once, and a byte that is cut short is dropped. A read takes a snapshot of the addressed register when the command byte ends, and shifts that snapshot out. Register contents are right-justified: bits above a register's width are dropped on a write and read back as zero.

When the last data bit has passed, the port returns to command mode by itself, so the select line may be held low. Raising the select line at any point ends the transfer and releases the data output. The current register contents are presented to the core on a flat bus.

Top module: `cmd_serial_regbank`

## Requirements
- R1: After reset every register holds zero, the output enable is low, and the first 8 bits clocked in are taken as a command byte.
- R2: A command byte is the first 8 bits after the select goes low, or after a completed transfer. Bit 7 set means write and bit 7 clear means read. Bits 4:0 are the register address. A command cut short by raising the select leaves no trace, and the next transfer decodes normally.
- R3: Data in is sampled on the falling serial clock edge. Data out changes only on a rising serial clock edge (or when the select rises).
- R4: The data phase is sent most significant bit first. For an address below 16, the width is fixed by address modulo 4: 0 gives 8 bits in 1 byte, 1 gives 12 bits in 2 bytes, 2 gives 16 bits in 2 bytes, and 3 gives 24 bits in 3 bytes.
- R5: Data is right-justified in its bytes. On a write, bits above the register width are ignored. On a read, those bits return as zero.
- R6: During a write, each completed data byte goes into its byte lane at once: the first byte goes to the most significant lane. A byte cut off by the select rising is not written, and the lanes written before it keep their new value.
- R7: Raising the select ends any transfer and drops the output enable. The next transfer starts again with a command byte.
- R8: After the last data bit of the addressed register, the port returns to command mode without the select toggling. Back-to-back transfers under one low select work correctly.
- R9: Addresses 16 to 31 are unmapped. They take 1 data byte, a write to them changes no register, and a read from them returns zero.
- R10: The output enable is high only while the select is low and a read data phase is in progress. It stays low during command bytes and write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| csn_i | input | 1 | Active-low select from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host, valid while sdo_oe_o is high |
| sdo_oe_o | output | 1 | Drive enable for the serial data output; low means high impedance |
| regs_o | output | NUM_REGS*24 | Register contents, register i at bits [24*i+23:24*i] |

## Verification
The bench writes registers of every width and reads them back. This shows whether the byte count and the right-justification are correct: a design that counted bytes wrongly would shift the following bits out of place, and one that kept the upper bits would read back extra ones. The bench cuts a write off partway through its second byte and expects only the first lane to change. A design that committed at the end of the transfer would lose that lane, and one that committed partial bytes would corrupt the next lane. Under one held-low select, the bench runs writes, including a write to an unmapped address, followed by reads. A port that did not return to command mode by itself, or that used the wrong byte count for an unmapped address, would read back wrong values. The bench also aborts a command and a read, then checks that the output enable drops and that the next command decodes cleanly.

// File: rtl/sr_pkg.sv
// Shared constants, phase type and the per-address width table of the
// serial register slave. Assumes at most 32 registers (5-bit address).
package sr_pkg;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned MAX_BYTES = 3;
    localparam int unsigned DATA_W    = 8 * MAX_BYTES;
    localparam int unsigned NB_W      = $clog2(MAX_BYTES + 1);
    localparam int unsigned CNT_W     = NB_W + 3;

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    // Bit width of a register; zero marks an unmapped address.
    function automatic int unsigned reg_width(input logic [ADDR_W-1:0] a,
                                              input int unsigned n_regs);
        if (int'(a) >= int'(n_regs)) return 0;
        case (a[1:0])
            2'd0:    return 8;
            2'd1:    return 12;
            2'd2:    return 16;
            default: return 24;
        endcase
    endfunction

    // Data byte count of a register; unmapped addresses take one byte.
    function automatic logic [NB_W-1:0] reg_bytes(input logic [ADDR_W-1:0] a,
                                                  input int unsigned n_regs);
        int unsigned w;
        w = reg_width(a, n_regs);
        if (w == 0) return NB_W'(1);
        return NB_W'((w + 7) / 8);
    endfunction

    // Mask of the low w bits of a data word.
    function automatic logic [DATA_W-1:0] width_mask(input int unsigned w);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < int'(DATA_W); i++) m[i] = (i < int'(w));
        return m;
    endfunction
endpackage

// File: rtl/sr_in_sync.sv
// Two-flop synchronizer for a group of asynchronous single-bit inputs.
// Assumes each bit is independent; RST_VAL gives each bit's idle level.
module sr_in_sync #(
    parameter int unsigned     N       = 3,
    parameter logic [N-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;

    // Two register stages per input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/sr_frame_ctrl.sv
// Command/data sequencer of the serial port. Detects serial clock edges on
// synchronized inputs, decodes the command byte, issues byte-lane writes,
// and shifts a read snapshot out. Assumes each serial clock half period
// spans at least 4 system clocks.
module sr_frame_ctrl
    import sr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              csn_s_i,
    input  logic              sdi_s_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [NB_W-1:0]   wr_lane_o,
    output logic [7:0]        wr_byte_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);
    phase_e            phase_q;
    logic              sclk_prev_q;
    logic [7:0]        cmd_q;
    logic [7:0]        byte_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [NB_W-1:0]   nb_q;
    logic [DATA_W-1:0] shadow_q;
    logic              sdo_q;

    logic              sclk_fall;
    logic              sclk_rise;
    logic [7:0]        cmd_next;
    logic [7:0]        byte_next;
    logic [NB_W-1:0]   cmd_nb;
    logic [CNT_W-1:0]  pad_bits;
    logic [CNT_W-1:0]  last_bit;

    // Edge detection and next-value helpers.
    assign sclk_fall = sclk_prev_q & ~sclk_s_i;
    assign sclk_rise = ~sclk_prev_q & sclk_s_i;
    assign cmd_next  = {cmd_q[6:0], sdi_s_i};
    assign byte_next = {byte_q[6:0], sdi_s_i};
    assign cmd_nb    = reg_bytes(cmd_next[ADDR_W-1:0], NUM_REGS);
    assign pad_bits  = {NB_W'(MAX_BYTES) - cmd_nb, 3'b000};
    assign last_bit  = {nb_q, 3'b000} - CNT_W'(1);

    // Remember the previous synchronized serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b1;
        else        sclk_prev_q <= sclk_s_i;
    end

    // Phase, bit counting, command capture and read shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_CMD;
            cmd_q    <= '0;
            byte_q   <= '0;
            cnt_q    <= '0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            nb_q     <= NB_W'(1);
            shadow_q <= '0;
            sdo_q    <= 1'b0;
        end else if (csn_s_i) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            sdo_q   <= 1'b0;
        end else if (sclk_fall) begin
            if (phase_q == PH_CMD) begin
                cmd_q <= cmd_next;
                if (cnt_q == CNT_W'(7)) begin
                    cnt_q   <= '0;
                    phase_q <= PH_DATA;
                    wr_q    <= cmd_next[7];
                    addr_q  <= cmd_next[ADDR_W-1:0];
                    nb_q    <= cmd_nb;
                    if (!cmd_next[7]) shadow_q <= rd_data_i << pad_bits;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else begin
                byte_q <= byte_next;
                if (cnt_q == last_bit) begin
                    phase_q <= PH_CMD;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end else if (sclk_rise && phase_q == PH_DATA && !wr_q) begin
            sdo_q    <= shadow_q[DATA_W-1];
            shadow_q <= shadow_q << 1;
        end
    end

    // Byte-lane write request on each completed write data byte.
    always_comb begin
        wr_en_o   = !csn_s_i && sclk_fall && phase_q == PH_DATA && wr_q
                    && cnt_q[2:0] == 3'd7;
        wr_addr_o = addr_q;
        wr_lane_o = nb_q - NB_W'(1) - cnt_q[CNT_W-1:3];
        wr_byte_o = byte_next;
    end

    // Read address for the snapshot taken as the command completes.
    assign rd_addr_o = cmd_next[ADDR_W-1:0];

    // Output drive only during a selected read data phase.
    assign sdo_oe_o = !csn_s_i && phase_q == PH_DATA && !wr_q;
    assign sdo_o    = sdo_oe_o & sdo_q;

    assert_data_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DATA) |-> (cnt_q <= last_bit));

    assert_abort_to_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s_i |=> (phase_q == PH_CMD && cnt_q == '0));

    assert_launch_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !csn_s_i) |=> $stable(sdo_q));

    assert_commit_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (cnt_q[2:0] == 3'd0));
endmodule

// File: rtl/sr_reg_bank.sv
// Register storage with byte-lane writes and a right-justified read port.
// Assumes lanes above a register's byte count are never addressed; bits
// above the register width are masked off on every write.
module sr_reg_bank
    import sr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [NB_W-1:0]              wr_lane_i,
    input  logic [7:0]                   wr_byte_i,
    input  logic [ADDR_W-1:0]            rd_addr_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic                       wr_unmapped;

    for (genvar i = 0; i < int'(NUM_REGS); i++) begin : g_reg
        localparam logic [DATA_W-1:0] MASK =
            width_mask(reg_width(ADDR_W'(i), NUM_REGS));
        logic [DATA_W-1:0] val_q;
        logic [DATA_W-1:0] val_d;

        // Merge the incoming byte into its lane, masked to the width.
        always_comb begin
            val_d = val_q;
            if (wr_en_i && wr_addr_i == ADDR_W'(i)) begin
                for (int b = 0; b < int'(MAX_BYTES); b++) begin
                    if (wr_lane_i == NB_W'(b))
                        val_d[b*8 +: 8] = wr_byte_i & MASK[b*8 +: 8];
                end
            end
        end

        // Register storage.
        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_flat[i*DATA_W +: DATA_W] = val_q;

        assert_unused_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (val_q & ~MASK) == '0);
    end

    // Read multiplexer; unmapped addresses give zero.
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = regs_flat[i*DATA_W +: DATA_W];
        end
    end

    assign regs_o      = regs_flat;
    assign wr_unmapped = wr_en_i && (int'(wr_addr_i) >= int'(NUM_REGS));

    assert_unmapped_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_unmapped |=> $stable(regs_flat));
endmodule

// File: rtl/cmd_serial_regbank.sv
// Top of the command-byte serial register slave: synchronizes the serial
// pins, then connects the sequencer to the register bank. Assumes the
// host keeps each serial clock half period at 4 system clocks or more.
module cmd_serial_regbank
    import sr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       csn_i,
    input  logic                       sdi_i,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    localparam int unsigned N_IN = 3;

    logic [N_IN-1:0]   pins_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [NB_W-1:0]   wr_lane;
    logic [7:0]        wr_byte;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    sr_in_sync #(.N(N_IN), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sdi_i, csn_i, sclk_i}),
        .q_o   (pins_s)
    );

    sr_frame_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s_i  (pins_s[0]),
        .csn_s_i   (pins_s[1]),
        .sdi_s_i   (pins_s[2]),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_lane_o (wr_lane),
        .wr_byte_o (wr_byte),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o)
    );

    sr_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_lane_i (wr_lane),
        .wr_byte_i (wr_byte),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    assert_oe_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pins_s[1]) |-> !sdo_oe_o);
endmodule

// File: tb/cmd_serial_regbank_bench.sv
// Self-checking bench: a vector table of write/read-back pairs, then
// directed tests for reset, aborts, held-low select and output enable.
module cmd_serial_regbank_bench;
    localparam int NREG = 16;
    localparam int HP   = 8;   // serial clock half period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic csn = 1'b1;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;
    logic [NREG*24-1:0] regs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cmd_serial_regbank #(.NUM_REGS(NREG)) u_cmd_serial_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk),
        .csn_i    (csn),
        .sdi_i    (sdi),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe),
        .regs_o   (regs)
    );

    // {address, write data (right-justified), expected read-back}
    localparam logic [52:0] VEC [10] = '{
        {5'd0,  24'h0000A5, 24'h0000A5},
        {5'd1,  24'h00FABC, 24'h000ABC},
        {5'd2,  24'h00BEEF, 24'h00BEEF},
        {5'd3,  24'h123456, 24'h123456},
        {5'd5,  24'h00F00F, 24'h00000F},
        {5'd7,  24'hC0FFEE, 24'hC0FFEE},
        {5'd20, 24'h000077, 24'h000000},
        {5'd15, 24'hFFFFFF, 24'hFFFFFF},
        {5'd13, 24'h00FFFF, 24'h000FFF},
        {5'd8,  24'h0000FF, 24'h0000FF}
    };

    function automatic int nbytes(input int a);
        if (a >= NREG) return 1;
        case (a % 4)
            0:       return 1;
            1:       return 2;
            2:       return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic [23:0] regv(input int a);
        return regs[a*24 +: 24];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bit_xfer(input logic tx, output logic rx, output logic oe);
        sdi = tx;
        wait_clk(HP);
        rx = sdo;
        oe = sdo_oe;
        sclk = 1'b0;
        wait_clk(HP);
        sclk = 1'b1;
    endtask

    task automatic xfer_bits(input int n, input logic [23:0] tx,
                             output logic [23:0] rx, output logic oe_all);
        logic r;
        logic o;
        rx = '0;
        oe_all = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            bit_xfer(tx[i], r, o);
            rx = {rx[22:0], r};
            oe_all = oe_all & o;
        end
    endtask

    task automatic begin_tx();
        csn = 1'b0;
        wait_clk(4);
    endtask

    task automatic end_tx();
        wait_clk(HP);
        csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic write_reg(input int a, input logic [23:0] d, input bit own_cs);
        logic [23:0] rx;
        logic oe;
        if (own_cs) begin_tx();
        xfer_bits(8, {16'h0, 3'b100, 5'(a)}, rx, oe);
        xfer_bits(8 * nbytes(a), d, rx, oe);
        if (own_cs) end_tx();
    endtask

    task automatic read_reg(input int a, input bit own_cs,
                            output logic [23:0] val, output logic oe_ok);
        logic [23:0] rx;
        logic oe;
        if (own_cs) begin_tx();
        xfer_bits(8, {16'h0, 3'b000, 5'(a)}, rx, oe);
        xfer_bits(8 * nbytes(a), 24'h0, val, oe_ok);
        if (own_cs) end_tx();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait_clk(190000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic oe_ok;
        logic [23:0] rx;
        logic oe;
        logic [NREG*24-1:0] snap;

        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);

        // R1: reset state
        check("R1 oe after reset", {23'h0, sdo_oe}, 24'h0);
        check("R1 regs zero", {23'h0, |regs}, 24'h0);
        read_reg(3, 1'b1, v, oe_ok);
        check("R1 first read zero", v, 24'h0);
        check("R10 oe in read data", {23'h0, oe_ok}, 24'h1);

        // R4 R5 R6 R9: table of write / read-back pairs
        for (int k = 0; k < 10; k++) begin
            int a;
            a = int'(VEC[k][52:48]);
            write_reg(a, VEC[k][47:24], 1'b1);
            read_reg(a, 1'b1, v, oe_ok);
            check("R4/R5 read-back", v, VEC[k][23:0]);
            if (a < NREG) check("R6 lane contents", regv(a), VEC[k][23:0]);
        end

        // R9: write to unmapped address changes nothing
        snap = regs;
        write_reg(31, 24'hFF, 1'b1);
        check("R9 unmapped write ignored", {23'h0, regs == snap}, 24'h1);

        // R10: no drive during write data
        begin_tx();
        xfer_bits(8, 24'h82, rx, oe);
        wait_clk(4);
        check("R10 oe low in write", {23'h0, sdo_oe}, 24'h0);
        xfer_bits(16, 24'h4321, rx, oe);
        end_tx();
        check("R6 full write", regv(2), 24'h4321);

        // R6 R7: abort inside second data byte of a 3-byte write
        begin_tx();
        xfer_bits(8, 24'h83, rx, oe);
        xfer_bits(8, 24'hAB, rx, oe);
        xfer_bits(4, 24'hF, rx, oe);
        end_tx();
        check("R6 partial byte dropped", regv(3), 24'hAB3456);
        check("R7 oe after abort", {23'h0, sdo_oe}, 24'h0);
        read_reg(3, 1'b1, v, oe_ok);
        check("R7 clean restart", v, 24'hAB3456);

        // R7 R10: abort in the middle of a read
        begin_tx();
        xfer_bits(8, 24'h02, rx, oe);
        xfer_bits(4, 24'h0, rx, oe);
        check("R10 oe during read", {23'h0, oe}, 24'h1);
        end_tx();
        check("R7 oe drops on abort", {23'h0, sdo_oe}, 24'h0);
        read_reg(2, 1'b1, v, oe_ok);
        check("R7 read after abort", v, 24'h4321);

        // R2: command cut short, then a fresh command
        begin_tx();
        xfer_bits(5, 24'h13, rx, oe);
        end_tx();
        write_reg(6, 24'h1357, 1'b1);
        read_reg(6, 1'b1, v, oe_ok);
        check("R2 after partial command", v, 24'h1357);

        // R8 R9: back-to-back transfers under one held-low select
        begin_tx();
        write_reg(0, 24'h3C, 1'b0);
        write_reg(1, 24'h123, 1'b0);
        write_reg(20, 24'h99, 1'b0);
        read_reg(0, 1'b0, v, oe_ok);
        check("R8 chained read reg0", v, 24'h3C);
        read_reg(1, 1'b0, v, oe_ok);
        check("R8 chained read reg1", v, 24'h123);
        end_tx();

        // R1: reset with populated registers
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        check("R1 regs cleared", {23'h0, |regs}, 24'h0);
        check("R1 oe cleared", {23'h0, sdo_oe}, 24'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule